// File: doc/BRIEF.md
# Serial Nonvolatile Memory Slave (Three-Wire Bus)

This block models the device side of a three-wire serial memory with a chip select, a serial clock, a data input and a data output. The design samples all bus pins with a fast internal clock. It decodes the instruction stream into reads, single-location programming, erases, whole-array operations, and the commands that enable and disable programming. The storage is a register array. A pin selects whether the array is addressed as 8-bit bytes or as 16-bit words.

A read streams data continuously while select stays high. The location address steps on after every location and wraps at the top of the array. Programming is self-timed by a counter on the internal clock, so the serial clock may stop once the operation has started. While the counter runs, raising select shows busy or ready on the data output.

Top module: `mw_eeprom`

## Requirements
- R1: After reset every byte of the array holds 0xFF. While select is low the output enable is low. While select is high with nothing in progress, the output is 1.
- R2: A frame is a start bit of 1, then a 2-bit opcode, then the address, all sent MSB first. Zeros sent before the start bit are ignored. The opcodes are 10 = read, 01 = write, 11 = erase and 00 = special. The address is 7 bits in byte mode and 6 bits in word mode. For the special opcode, the two top address bits select the command: 11 = enable, 00 = disable, 10 = erase all, 01 = write all.
- R3: After reset, and after a disable command, write, erase, erase-all and write-all change nothing and do not make the device busy. They take effect again after an enable command.
- R4: A read first drives a 0 bit on the output after the last address bit. It then drives the data MSB first, one bit after each following rising edge of the serial clock.
- R5: While select stays high, a read continues with the next location and no extra 0 bit. After the highest location it continues at location 0.
- R6: With org = 1, word a is made of byte 2a in bits 15:8 and byte 2a+1 in bits 7:0. With org = 0, each location is one byte.
- R7: A write replaces one location (a byte or a word, depending on org) with the data that follows the address, whatever the location held before. Programming starts when select goes low after the last data bit.
- R8: Programming lasts PROG_CYCLES internal clocks and needs no serial clock edges. While it runs and select is high, the output is 0. Once it has finished, the output is 1.
- R9: An erase sets one location to all ones and leaves every other location unchanged.
- R10: Erase-all sets the whole array to all ones. Write-all stores its data in every location; in word mode the bytes alternate between the high and low data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal free-running clock |
| rst_n | input | 1 | Active-low reset |
| cs | input | 1 | Chip select, active high |
| sck | input | 1 | Serial clock, data sampled on rising edge |
| din | input | 1 | Serial data in |
| org | input | 1 | Organization: 1 = 16-bit words, 0 = bytes |
| dout | output | 1 | Serial data / ready status out |
| dout_oe | output | 1 | Output enable for dout (high while selected) |

## Verification
Every byte address is written in byte mode with a distinct arithmetic pattern. One unbroken read then covers the whole array and runs past the top. This separates a wrong address step, a missing wrap and a spurious dummy bit between locations. The same contents are read back in word mode, which exposes byte-lane swaps and word-address errors. Single erases and word writes are checked against their neighbours to catch writes that spread. Whole-array fills with alternating byte values, and programming commands sent after a disable, show whether the enable gate and the busy polling behave.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_DATA,
        ST_READ,
        ST_HOLD
    } st_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_WRITE,
        OP_ERASE,
        OP_ERAL,
        OP_WRAL
    } op_e;

    localparam logic [1:0] OPC_READ    = 2'b10;
    localparam logic [1:0] OPC_WRITE   = 2'b01;
    localparam logic [1:0] OPC_ERASE   = 2'b11;
    localparam logic [1:0] OPC_SPECIAL = 2'b00;

    localparam logic [1:0] SUB_EN      = 2'b11;
    localparam logic [1:0] SUB_DIS     = 2'b00;
    localparam logic [1:0] SUB_ERAL    = 2'b10;
    localparam logic [1:0] SUB_WRAL    = 2'b01;

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s0_q, s0_d, s1_q, s1_d;

    always_comb begin
        s0_d = d;
        s1_d = s0_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s0_q <= '0;
            s1_q <= '0;
        end else begin
            s0_q <= s0_d;
            s1_q <= s1_d;
        end
    end

    assign q = s1_q;
endmodule

// File: rtl/mw_ctrl.sv
module mw_ctrl
    import mw_pkg::*;
#(
    parameter int ABITS = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs,
    input  logic             sck,
    input  logic             din,
    input  logic             org,
    input  logic             busy,
    input  logic [15:0]      rd_word,
    output logic [ABITS-1:0] rd_addr,
    output logic             rd_org,
    output logic             prog_start,
    output op_e              prog_op,
    output logic [ABITS-1:0] prog_addr,
    output logic [15:0]      prog_data,
    output logic             prog_org,
    output logic             dout
);
    localparam logic [4:0] AW_BYTE = 5'(ABITS - 1);
    localparam logic [4:0] AW_WORD = 5'(ABITS - 2);
    localparam logic [4:0] DW_BYTE = 5'd7;
    localparam logic [4:0] DW_WORD = 5'd15;

    typedef struct packed {
        st_e              st;
        logic [1:0]       opc;
        logic [ABITS-1:0] sh_addr;
        logic [15:0]      sh_data;
        logic [4:0]       cnt;
        logic [ABITS-1:0] addr;
        logic             en;
        op_e              pend;
        logic             sck_p;
        logic             cs_p;
        logic             qbit;
        logic             org_l;
    } ctl_t;

    ctl_t q_q, n_d;
    logic             rise, cs_fall, start_c;
    logic [ABITS-1:0] a_next, a_inc;
    logic [1:0]       sub;

    always_comb begin
        n_d       = q_q;
        start_c   = 1'b0;
        n_d.sck_p = sck;
        n_d.cs_p  = cs;
        rise      = sck & ~q_q.sck_p & cs;
        cs_fall   = q_q.cs_p & ~cs;
        a_next    = {q_q.sh_addr[ABITS-2:0], din};
        sub       = q_q.org_l ? a_next[ABITS-2 -: 2] : a_next[ABITS-1 -: 2];
        a_inc     = q_q.addr + 1'b1;
        if (q_q.org_l) a_inc[ABITS-1] = 1'b0;

        if (!cs) begin
            n_d.st = ST_IDLE;
            if (cs_fall && q_q.pend != OP_NONE) begin
                start_c  = q_q.en & ~busy;
                n_d.pend = OP_NONE;
            end
        end else if (rise) begin
            case (q_q.st)
                ST_IDLE: begin
                    if (din && !busy) begin
                        n_d.st      = ST_OPC;
                        n_d.cnt     = 5'd1;
                        n_d.org_l   = org;
                        n_d.pend    = OP_NONE;
                        n_d.sh_addr = '0;
                    end
                end
                ST_OPC: begin
                    n_d.opc = {q_q.opc[0], din};
                    if (q_q.cnt == 5'd0) begin
                        n_d.st  = ST_ADDR;
                        n_d.cnt = q_q.org_l ? AW_WORD : AW_BYTE;
                    end else begin
                        n_d.cnt = q_q.cnt - 5'd1;
                    end
                end
                ST_ADDR: begin
                    n_d.sh_addr = a_next;
                    if (q_q.cnt == 5'd0) begin
                        n_d.addr = a_next;
                        n_d.st   = ST_HOLD;
                        case (q_q.opc)
                            OPC_READ: begin
                                n_d.st   = ST_READ;
                                n_d.cnt  = 5'd0;
                                n_d.qbit = 1'b0;
                            end
                            OPC_WRITE: begin
                                n_d.st      = ST_DATA;
                                n_d.sh_data = '0;
                                n_d.cnt     = q_q.org_l ? DW_WORD : DW_BYTE;
                            end
                            OPC_ERASE: n_d.pend = OP_ERASE;
                            default: begin
                                case (sub)
                                    SUB_EN:   n_d.en   = 1'b1;
                                    SUB_DIS:  n_d.en   = 1'b0;
                                    SUB_ERAL: n_d.pend = OP_ERAL;
                                    default: begin
                                        n_d.st      = ST_DATA;
                                        n_d.sh_data = '0;
                                        n_d.cnt     = q_q.org_l ? DW_WORD : DW_BYTE;
                                    end
                                endcase
                            end
                        endcase
                    end else begin
                        n_d.cnt = q_q.cnt - 5'd1;
                    end
                end
                ST_DATA: begin
                    n_d.sh_data = {q_q.sh_data[14:0], din};
                    if (q_q.cnt == 5'd0) begin
                        n_d.st   = ST_HOLD;
                        n_d.pend = (q_q.opc == OPC_WRITE) ? OP_WRITE : OP_WRAL;
                    end else begin
                        n_d.cnt = q_q.cnt - 5'd1;
                    end
                end
                ST_READ: begin
                    if (q_q.cnt == 5'd0) begin
                        n_d.addr = a_inc;
                        if (q_q.org_l) begin
                            n_d.qbit    = rd_word[15];
                            n_d.sh_data = {rd_word[14:0], 1'b0};
                            n_d.cnt     = DW_WORD;
                        end else begin
                            n_d.qbit    = rd_word[7];
                            n_d.sh_data = {rd_word[6:0], 9'b0};
                            n_d.cnt     = DW_BYTE;
                        end
                    end else begin
                        n_d.qbit    = q_q.sh_data[15];
                        n_d.sh_data = {q_q.sh_data[14:0], 1'b0};
                        n_d.cnt     = q_q.cnt - 5'd1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '{st: ST_IDLE, pend: OP_NONE, default: '0};
        end else begin
            q_q <= n_d;
        end
    end

    assign rd_addr    = q_q.addr;
    assign rd_org     = q_q.org_l;
    assign prog_start = start_c;
    assign prog_op    = q_q.pend;
    assign prog_addr  = q_q.addr;
    assign prog_data  = q_q.sh_data;
    assign prog_org   = q_q.org_l;
    assign dout       = (q_q.st == ST_READ) ? q_q.qbit : ~busy;

    AST_READ_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.st == ST_READ) |-> $past(cs)); // R4
    AST_ENABLE_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q_q.en) |-> $past(cs)); // R3
endmodule

// File: rtl/mw_prog.sv
module mw_prog
    import mw_pkg::*;
#(
    parameter int ABITS       = 7,
    parameter int PROG_CYCLES = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  op_e              op_in,
    input  logic [ABITS-1:0] addr_in,
    input  logic [15:0]      data_in,
    input  logic             org_in,
    output logic             busy,
    output logic             commit,
    output op_e              op,
    output logic [ABITS-1:0] addr,
    output logic [15:0]      data,
    output logic             org
);
    localparam int CW = $clog2(PROG_CYCLES + 1);
    localparam logic [CW-1:0] CNT_INIT = CW'(PROG_CYCLES - 1);

    typedef struct packed {
        logic             busy;
        logic [CW-1:0]    cnt;
        op_e              op;
        logic [ABITS-1:0] addr;
        logic [15:0]      data;
        logic             org;
    } prg_t;

    prg_t q_q, n_d;
    logic done_c;

    always_comb begin
        n_d    = q_q;
        done_c = q_q.busy && (q_q.cnt == '0);
        if (start && !q_q.busy) begin
            n_d.busy = 1'b1;
            n_d.cnt  = CNT_INIT;
            n_d.op   = op_in;
            n_d.addr = addr_in;
            n_d.data = data_in;
            n_d.org  = org_in;
        end else if (done_c) begin
            n_d.busy = 1'b0;
        end else if (q_q.busy) begin
            n_d.cnt = q_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '{op: OP_NONE, default: '0};
        else        q_q <= n_d;
    end

    assign busy   = q_q.busy;
    assign commit = done_c;
    assign op     = q_q.op;
    assign addr   = q_q.addr;
    assign data   = q_q.data;
    assign org    = q_q.org;

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.busy |-> (q_q.cnt <= CNT_INIT)); // R8
endmodule

// File: rtl/mw_array.sv
module mw_array
    import mw_pkg::*;
#(
    parameter int ABITS = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  op_e              op,
    input  logic [ABITS-1:0] addr,
    input  logic [15:0]      data,
    input  logic             org,
    input  logic [ABITS-1:0] rd_addr,
    input  logic             rd_org,
    output logic [15:0]      rd_word
);
    localparam int BYTES = 2 ** ABITS;

    logic [7:0] mem_q [BYTES];
    logic [7:0] mem_d [BYTES];

    for (genvar i = 0; i < BYTES; i++) begin : g_byte
        localparam logic [ABITS-1:0] IDX = ABITS'(i);
        logic hit_c, lane_hi_c;
        always_comb begin
            lane_hi_c = org & ~IDX[0];
            hit_c     = org ? (addr[ABITS-2:0] == IDX[ABITS-1:1]) : (addr == IDX);
            mem_d[i]  = mem_q[i];
            if (commit) begin
                case (op)
                    OP_WRITE: if (hit_c) mem_d[i] = lane_hi_c ? data[15:8] : data[7:0];
                    OP_ERASE: if (hit_c) mem_d[i] = 8'hFF;
                    OP_ERAL:  mem_d[i] = 8'hFF;
                    OP_WRAL:  mem_d[i] = lane_hi_c ? data[15:8] : data[7:0];
                    default: ;
                endcase
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[i] <= 8'hFF;
            else        mem_q[i] <= mem_d[i];
        end
    end

    always_comb begin
        if (rd_org) rd_word = {mem_q[{rd_addr[ABITS-2:0], 1'b0}], mem_q[{rd_addr[ABITS-2:0], 1'b1}]};
        else        rd_word = {8'h00, mem_q[rd_addr]};
    end
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
    import mw_pkg::*;
#(
    parameter int MEM_BITS    = 1024,
    parameter int PROG_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sck,
    input  logic din,
    input  logic org,
    output logic dout,
    output logic dout_oe
);
    localparam int BYTES = MEM_BITS / 8;
    localparam int ABITS = $clog2(BYTES);

    logic [3:0]       pins_s;
    logic             busy, commit, prog_start, rd_org, prog_org, c_org;
    op_e              prog_op, c_op;
    logic [ABITS-1:0] rd_addr, prog_addr, c_addr;
    logic [15:0]      prog_data, c_data, rd_word;

    mw_sync #(.W(4)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({cs, sck, din, org}), .q(pins_s)
    );

    mw_ctrl #(.ABITS(ABITS)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cs(pins_s[3]), .sck(pins_s[2]), .din(pins_s[1]), .org(pins_s[0]),
        .busy(busy), .rd_word(rd_word), .rd_addr(rd_addr), .rd_org(rd_org),
        .prog_start(prog_start), .prog_op(prog_op), .prog_addr(prog_addr),
        .prog_data(prog_data), .prog_org(prog_org), .dout(dout)
    );

    mw_prog #(.ABITS(ABITS), .PROG_CYCLES(PROG_CYCLES)) u_prog (
        .clk(clk), .rst_n(rst_n), .start(prog_start),
        .op_in(prog_op), .addr_in(prog_addr), .data_in(prog_data), .org_in(prog_org),
        .busy(busy), .commit(commit), .op(c_op), .addr(c_addr), .data(c_data), .org(c_org)
    );

    mw_array #(.ABITS(ABITS)) u_array (
        .clk(clk), .rst_n(rst_n), .commit(commit), .op(c_op), .addr(c_addr),
        .data(c_data), .org(c_org), .rd_addr(rd_addr), .rd_org(rd_org), .rd_word(rd_word)
    );

    assign dout_oe = pins_s[3];

    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> !busy); // R8
    AST_START_MAKES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> busy); // R7
endmodule

// File: tb/mw_eeprom_tb.sv
module mw_eeprom_tb;
    localparam int PC = 40;

    logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sck = 1'b0, din = 1'b0, org = 1'b0;
    wire  dout, dout_oe;
    int   checks = 0, errors = 0;
    bit   en = 1'b0;
    logic [7:0] mdl [128];

    always #4 clk = ~clk;

    mw_eeprom #(.MEM_BITS(1024), .PROG_CYCLES(PC)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sck(sck), .din(din), .org(org),
        .dout(dout), .dout_oe(dout_oe)
    );

    task automatic chk(input string r, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic xfer(input logic b, output logic q);
        @(negedge clk);
        q   = dout;
        din = b;
        repeat (4) @(negedge clk);
        sck = 1'b1;
        repeat (4) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic cs_on;
        @(negedge clk); cs = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_off;
        @(negedge clk); cs = 1'b0; din = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic send(input logic [31:0] v, input int n);
        logic q;
        for (int i = n - 1; i >= 0; i--) xfer(v[i], q);
    endtask

    task automatic header(input logic [1:0] op, input logic [6:0] a);
        cs_on();
        send({29'd0, 1'b1, op}, 3);
        send({25'd0, a}, org ? 6 : 7);
    endtask

    // after cs has gone low: poll busy then ready (R8), or no busy if ignored (R3)
    task automatic finish_prog(input bit expect_busy);
        cs_on();
        if (expect_busy) begin
            chk("R8 busy", {15'd0, dout}, 16'd0);
            repeat (PC + 10) @(negedge clk);
            chk("R8 ready", {15'd0, dout}, 16'd1);
        end else begin
            chk("R3 no busy", {15'd0, dout}, 16'd1);
        end
        cs_off();
    endtask

    task automatic rd_check(input logic [6:0] a, input int n, input string tag);
        logic q;
        logic [15:0] got, exp;
        int nloc, loc, dw;
        nloc = org ? 64 : 128;
        dw   = org ? 16 : 8;
        header(2'b10, a);
        xfer(1'b0, q);
        chk("R4 dummy", {15'd0, q}, 16'd0);
        for (int k = 0; k < n; k++) begin
            loc = (int'(a) + k) % nloc;
            exp = org ? {mdl[2*loc], mdl[2*loc+1]} : {8'h00, mdl[loc]};
            got = '0;
            for (int b = 0; b < dw; b++) begin
                xfer(1'b0, q);
                got = {got[14:0], q};
            end
            chk(tag, got, exp);
        end
        cs_off();
    endtask

    task automatic cmd_special(input logic [1:0] sub);
        header(2'b00, org ? {1'b0, sub, 4'd0} : {sub, 5'd0});
        cs_off();
    endtask

    task automatic wr(input logic [6:0] a, input logic [15:0] d);
        header(2'b01, a);
        send({16'd0, d}, org ? 16 : 8);
        cs_off();
        finish_prog(en);
        if (en) begin
            if (org) begin mdl[2*a] = d[15:8]; mdl[2*a+1] = d[7:0]; end
            else mdl[a] = d[7:0];
        end
    endtask

    task automatic erase(input logic [6:0] a);
        header(2'b11, a);
        cs_off();
        finish_prog(en);
        if (en) begin
            if (org) begin mdl[2*a] = 8'hFF; mdl[2*a+1] = 8'hFF; end
            else mdl[a] = 8'hFF;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) mdl[i] = 8'hFF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset state
        chk("R1 oe low", {15'd0, dout_oe}, 16'd0);
        cs_on();
        chk("R1 oe high", {15'd0, dout_oe}, 16'd1);
        chk("R1 ready", {15'd0, dout}, 16'd1);
        cs_off();
        chk("R1 oe off", {15'd0, dout_oe}, 16'd0);
        rd_check(7'd0, 128, "R1 erased");

        // R3 write before enable is ignored
        wr(7'd3, 16'h0000);
        rd_check(7'd3, 1, "R3 locked");

        // R2 leading zeros then enable command
        cs_on();
        send(32'd0, 2);
        cs_off();
        cmd_special(2'b11);
        en = 1'b1;

        // R7 fill every byte with a pattern
        for (int a = 0; a < 128; a++) wr(7'(a), {8'h00, 8'((a * 29 + 7) & 8'hFF)});
        rd_check(7'd0, 130, "R5 stream wrap");
        rd_check(7'd125, 6, "R5 wrap mid");

        // R6 word view
        org = 1'b1;
        rd_check(7'd0, 65, "R6 word stream");
        rd_check(7'd62, 4, "R6 word wrap");
        wr(7'd10, 16'hBEEF);
        rd_check(7'd9, 3, "R7 word write");
        org = 1'b0;
        rd_check(7'd19, 4, "R6 word lanes");

        // R9 erase single location
        erase(7'd5);
        rd_check(7'd4, 3, "R9 byte erase");
        org = 1'b1;
        erase(7'd7);
        org = 1'b0;
        rd_check(7'd13, 4, "R9 word erase");

        // R3 disable blocks erase
        cmd_special(2'b00);
        en = 1'b0;
        erase(7'd6);
        rd_check(7'd6, 1, "R3 disabled erase");
        cmd_special(2'b11);
        en = 1'b1;

        // R10 write-all in word mode, erase-all in byte mode
        org = 1'b1;
        cmd_special(2'b01);
        header(2'b00, {1'b0, 2'b01, 4'd0});
        send({16'd0, 16'h1234}, 16);
        cs_off();
        finish_prog(1'b1);
        for (int i = 0; i < 128; i++) mdl[i] = (i % 2 == 0) ? 8'h12 : 8'h34;
        org = 1'b0;
        rd_check(7'd0, 128, "R10 write all");
        cmd_special(2'b10);
        finish_prog(1'b1);
        for (int i = 0; i < 128; i++) mdl[i] = 8'hFF;
        rd_check(7'd0, 128, "R10 erase all");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule